// File: doc/BRIEF.md
# Register Window Pointer Manager

This block keeps the bookkeeping state of a windowed register file. It holds five counters: the current window pointer, the number of windows that can still be saved, the number that can be restored, the number of clean windows, and the number of windows owned by another context. The number of windows is a parameter. A restore strobe steps the pointer back one window, wrapping from 0 to the highest window, and moves one unit from can-restore to can-save. In the same cycle the block issues a destination write into the window it has just moved to. The value written is the sum of the two source operands.

An accounting strobe applies the updates that a trap handler makes after it has spilled or filled a window. It has two kinds. The "saved" kind credits can-save. The "restored" kind credits can-restore and clean-windows. Both kinds draw their debit from other-windows first, and from the opposite counter only when other-windows is empty. Software state is loaded through a direct counter write port. When a restore finds nothing to restore, the block raises a fill-trap flag and leaves every counter as it was. Generating the trap itself is left to the surrounding logic.

All pins are plain control and status signals. The destination write is a single-cycle pulse with no ready signal, because the register file accepts a write on every cycle. A handshake would only add a stall path that is never used.

Top module: `rwin_ptr_mgr`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, the outputs read: pointer 0, can-save NWIN-2, can-restore 0, clean-windows NWIN-1, other-windows 0, and the fill-trap and destination-write flags both 0.
- R2: A restore while can-restore is nonzero sets the pointer to (pointer + NWIN - 1) mod NWIN one cycle later. From window 0 it goes to window NWIN-1.
- R3: A restore while can-restore is nonzero raises can-save by one and lowers can-restore by one. Can-save stops at NWIN-1.
- R4: A restore while can-restore is nonzero pulses the destination write for exactly one cycle. In that cycle the window output equals the new pointer and the data output equals (source A + source B) mod 2^DW.
- R5: A restore while can-restore is 0 changes no counter and makes no destination write. Instead it pulses the fill-trap flag for one cycle.
- R6: An accounting update of kind 0 ("saved") raises can-save by one, stopping at NWIN-1. If other-windows is nonzero it lowers other-windows by one; otherwise it lowers can-restore by one, stopping at 0.
- R7: An accounting update of kind 1 ("restored") raises can-restore by one, stopping at NWIN-1. It raises clean-windows only while clean-windows is below NWIN-1. If other-windows is nonzero it lowers other-windows by one; otherwise it lowers can-save by one, stopping at 0.
- R8: A direct write loads the field chosen by the select code: 0 pointer, 1 can-save, 2 can-restore, 3 clean-windows, 4 other-windows. A value above NWIN-1 is stored as NWIN-1. Select codes 5, 6 and 7 change nothing.
- R9: When strobes arrive together, restore takes precedence, accounting comes second and the direct write last. A strobe that loses is dropped for that cycle. This holds even when the winning restore is the one that traps.
- R10: No counter output ever exceeds NWIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restore_i | input | 1 | Restore strobe |
| src_a_i | input | DW | First source operand for the restore destination write |
| src_b_i | input | DW | Second source operand for the restore destination write |
| acct_i | input | 1 | Accounting update strobe |
| acct_kind_i | input | 1 | Accounting kind: 0 saved, 1 restored |
| wr_en_i | input | 1 | Direct counter write strobe |
| wr_sel_i | input | 3 | Field select for the direct write |
| wr_val_i | input | CW | Value for the direct write |
| cwp_o | output | CW | Current window pointer |
| cansave_o | output | CW | Can-save count |
| canrestore_o | output | CW | Can-restore count |
| cleanwin_o | output | CW | Clean-windows count |
| otherwin_o | output | CW | Other-windows count |
| fill_trap_o | output | 1 | Fill-trap request pulse |
| dst_we_o | output | 1 | Destination write pulse |
| dst_win_o | output | CW | Window index of the destination write |
| dst_data_o | output | DW | Destination write data |

## Verification
Every result of this block is due exactly one rising edge after the edge that samples the strobe. This covers the counter values, the pointer, the destination write with its window and sum, and the fill-trap pulse. The bench drives each strobe on a falling edge and compares all outputs on the following falling edge, after the single register stage has updated and well away from the next rising edge. It then clears the strobes, so no request is seen twice. A reference model in the bench advances by one operation per step, so each comparison matches exactly one stimulus.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  // Direct-write field select codes
  typedef enum logic [2:0] {
    SEL_CWP   = 3'd0,
    SEL_SAVE  = 3'd1,
    SEL_REST  = 3'd2,
    SEL_CLEAN = 3'd3,
    SEL_OTHER = 3'd4
  } rwin_sel_e;

  // Indexes of the saturating counters
  localparam int NCTR     = 4;
  localparam int IX_SAVE  = 0;
  localparam int IX_REST  = 1;
  localparam int IX_CLEAN = 2;
  localparam int IX_OTHER = 3;

  // Select code that addresses counter idx
  function automatic logic [2:0] ctr_sel(input int idx);
    return 3'(idx + 1);
  endfunction

  // Reset value of counter idx: a legal starting configuration
  function automatic int ctr_rst(input int idx, input int nwin);
    case (idx)
      IX_SAVE:  return nwin - 2;
      IX_CLEAN: return nwin - 1;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/rwin_sat_ctr.sv
module rwin_sat_ctr #(
  parameter int W    = 3,
  parameter int MAXV = 7,
  parameter int RSTV = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAXQ = W'(MAXV);
  localparam logic [W-1:0] RSTQ = W'(RSTV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o <= RSTQ;
    end else if (ld_i) begin
      q_o <= (ld_val_i > MAXQ) ? MAXQ : ld_val_i;
    end else if (inc_i) begin
      if (q_o != MAXQ) q_o <= q_o + 1'b1;
    end else if (dec_i) begin
      if (q_o != '0) q_o <= q_o - 1'b1;
    end
  end

  // R10
  ctr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o <= MAXQ);

  // R7
  ctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && q_o == MAXQ) |=> (q_o == MAXQ));

  // R6
  ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !ld_i && q_o == '0) |=> (q_o == '0));

endmodule

// File: rtl/rwin_cwp_ring.sv
module rwin_cwp_ring #(
  parameter int W    = 3,
  parameter int NWIN = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dec_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] TOPQ = W'(NWIN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (ld_i) begin
      q_o <= (ld_val_i > TOPQ) ? TOPQ : ld_val_i;
    end else if (dec_i) begin
      q_o <= (q_o == '0) ? TOPQ : (q_o - 1'b1);
    end
  end

  // R2
  cwp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !ld_i) |=>
      (q_o == (($past(q_o) == '0) ? TOPQ : ($past(q_o) - 1'b1))));

  // R10
  cwp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_o <= TOPQ);

endmodule

// File: rtl/rwin_restore_out.sv
module rwin_restore_out #(
  parameter int W  = 3,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire_i,
  input  logic          trap_i,
  input  logic [W-1:0]  win_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          we_o,
  output logic          trap_o,
  output logic [W-1:0]  win_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_o   <= 1'b0;
      trap_o <= 1'b0;
      win_o  <= '0;
      data_o <= '0;
    end else begin
      we_o   <= fire_i;
      trap_o <= trap_i;
      if (fire_i) begin
        win_o  <= win_i;
        data_o <= a_i + b_i;
      end
    end
  end

  // R5
  trap_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_o && trap_o));

  // R4
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i) |=> (we_o && data_o == ($past(a_i) + $past(b_i))));

endmodule

// File: rtl/rwin_ptr_mgr.sv
module rwin_ptr_mgr #(
  parameter int  NWIN = 8,
  parameter int  DW   = 64,
  localparam int CW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic          acct_i,
  input  logic          acct_kind_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [CW-1:0] wr_val_i,
  output logic [CW-1:0] cwp_o,
  output logic [CW-1:0] cansave_o,
  output logic [CW-1:0] canrestore_o,
  output logic [CW-1:0] cleanwin_o,
  output logic [CW-1:0] otherwin_o,
  output logic          fill_trap_o,
  output logic          dst_we_o,
  output logic [CW-1:0] dst_win_o,
  output logic [DW-1:0] dst_data_o
);
  import rwin_pkg::*;

  localparam logic [CW-1:0] TOPQ = CW'(NWIN - 1);

  logic [NCTR-1:0] inc_v, dec_v, ld_v;
  logic [CW-1:0]   ctr_q [NCTR];
  logic            restore_ok, restore_trap, acct_go, wr_go, other_zero;
  logic [CW-1:0]   prev_win;

  // Arbitration: restore, then accounting, then direct write
  always_comb begin
    restore_ok   = restore_i && (ctr_q[IX_REST] != '0);
    restore_trap = restore_i && (ctr_q[IX_REST] == '0);
    acct_go      = acct_i && !restore_i;
    wr_go        = wr_en_i && !restore_i && !acct_i;
    other_zero   = (ctr_q[IX_OTHER] == '0);
    prev_win     = (cwp_o == '0) ? TOPQ : (cwp_o - 1'b1);
  end

  // Counter step requests
  always_comb begin
    inc_v = '0;
    dec_v = '0;
    if (restore_ok) begin
      inc_v[IX_SAVE] = 1'b1;
      dec_v[IX_REST] = 1'b1;
    end
    if (acct_go && !acct_kind_i) begin
      inc_v[IX_SAVE] = 1'b1;
      if (other_zero) dec_v[IX_REST]  = 1'b1;
      else            dec_v[IX_OTHER] = 1'b1;
    end
    if (acct_go && acct_kind_i) begin
      inc_v[IX_REST]  = 1'b1;
      inc_v[IX_CLEAN] = 1'b1;
      if (other_zero) dec_v[IX_SAVE]  = 1'b1;
      else            dec_v[IX_OTHER] = 1'b1;
    end
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    assign ld_v[i] = wr_go && (wr_sel_i == ctr_sel(i));
    rwin_sat_ctr #(
      .W    (CW),
      .MAXV (NWIN - 1),
      .RSTV (ctr_rst(i, NWIN))
    ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (inc_v[i]),
      .dec_i    (dec_v[i]),
      .ld_i     (ld_v[i]),
      .ld_val_i (wr_val_i),
      .q_o      (ctr_q[i])
    );
  end

  rwin_cwp_ring #(
    .W    (CW),
    .NWIN (NWIN)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec_i    (restore_ok),
    .ld_i     (wr_go && (wr_sel_i == SEL_CWP)),
    .ld_val_i (wr_val_i),
    .q_o      (cwp_o)
  );

  rwin_restore_out #(
    .W  (CW),
    .DW (DW)
  ) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (restore_ok),
    .trap_i (restore_trap),
    .win_i  (prev_win),
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .we_o   (dst_we_o),
    .trap_o (fill_trap_o),
    .win_o  (dst_win_o),
    .data_o (dst_data_o)
  );

  assign cansave_o    = ctr_q[IX_SAVE];
  assign canrestore_o = ctr_q[IX_REST];
  assign cleanwin_o   = ctr_q[IX_CLEAN];
  assign otherwin_o   = ctr_q[IX_OTHER];

  // R5
  fill_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && canrestore_o == '0) |=>
      (fill_trap_o && !dst_we_o && $stable(cwp_o) && $stable(cansave_o) &&
       $stable(canrestore_o) && $stable(cleanwin_o) && $stable(otherwin_o)));

  // R4
  dst_win_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we_o |-> (dst_win_o == cwp_o));

  // R3
  restore_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && canrestore_o != '0) |=>
      (canrestore_o == $past(canrestore_o) - 1'b1));

  // R6
  acct_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acct_i && !restore_i && otherwin_o != '0) |=>
      (otherwin_o == $past(otherwin_o) - 1'b1));

  // R9
  prio_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && wr_en_i && wr_sel_i == SEL_OTHER && !acct_i) |=>
      $stable(otherwin_o));

endmodule

// File: tb/rwin_ptr_mgr_tb.sv
module rwin_ptr_mgr_tb;
  localparam int N  = 6;
  localparam int DW = 16;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          restore_i = 1'b0, acct_i = 1'b0, acct_kind_i = 1'b0, wr_en_i = 1'b0;
  logic [DW-1:0] src_a_i = '0, src_b_i = '0;
  logic [2:0]    wr_sel_i = '0;
  logic [CW-1:0] wr_val_i = '0;
  logic [CW-1:0] cwp_o, cansave_o, canrestore_o, cleanwin_o, otherwin_o, dst_win_o;
  logic          fill_trap_o, dst_we_o;
  logic [DW-1:0] dst_data_o;

  int checks = 0, errors = 0;
  int m_cwp, m_cs, m_cr, m_cl, m_ow;

  always #4 clk = ~clk;

  rwin_ptr_mgr #(.NWIN(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .restore_i(restore_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .acct_i(acct_i), .acct_kind_i(acct_kind_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_val_i(wr_val_i),
    .cwp_o(cwp_o), .cansave_o(cansave_o), .canrestore_o(canrestore_o),
    .cleanwin_o(cleanwin_o), .otherwin_o(otherwin_o), .fill_trap_o(fill_trap_o),
    .dst_we_o(dst_we_o), .dst_win_o(dst_win_o), .dst_data_o(dst_data_o)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int e_trap, input int e_we,
                         input int e_win, input logic [DW-1:0] e_data);
    chk(tag, "cwp", cwp_o, m_cwp);
    chk(tag, "cansave", cansave_o, m_cs);
    chk(tag, "canrestore", canrestore_o, m_cr);
    chk(tag, "cleanwin", cleanwin_o, m_cl);
    chk(tag, "otherwin", otherwin_o, m_ow);
    chk(tag, "fill_trap", fill_trap_o, e_trap);
    chk(tag, "dst_we", dst_we_o, e_we);
    if (e_we != 0) begin
      chk(tag, "dst_win", dst_win_o, e_win);
      chk(tag, "dst_data", dst_data_o, e_data);
    end
    // R10 bound on every counter
    chk("R10", "bound", (cwp_o <= N-1 && cansave_o <= N-1 && canrestore_o <= N-1 &&
        cleanwin_o <= N-1 && otherwin_o <= N-1) ? 1 : 0, 1);
  endtask

  // One operation: drive at a falling edge, results due one rising edge later
  task automatic step(input logic rs, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic ac, input logic kd, input logic we,
                      input int sel, input int val, input string tag);
    int e_trap = 0, e_we = 0, e_win = 0;
    logic [DW-1:0] e_data = '0;
    restore_i = rs; src_a_i = a; src_b_i = b; acct_i = ac; acct_kind_i = kd;
    wr_en_i = we; wr_sel_i = 3'(sel); wr_val_i = CW'(val);
    if (rs) begin
      if (m_cr == 0) e_trap = 1;
      else begin
        m_cwp = (m_cwp + N - 1) % N;
        if (m_cs < N-1) m_cs++;
        m_cr--;
        e_we = 1; e_win = m_cwp; e_data = a + b;
      end
    end else if (ac) begin
      if (!kd) begin
        if (m_cs < N-1) m_cs++;
        if (m_ow != 0) m_ow--; else if (m_cr != 0) m_cr--;
      end else begin
        if (m_cr < N-1) m_cr++;
        if (m_cl < N-1) m_cl++;
        if (m_ow != 0) m_ow--; else if (m_cs != 0) m_cs--;
      end
    end else if (we) begin
      int v;
      v = (val > N-1) ? N-1 : val;
      case (sel)
        0: m_cwp = v;
        1: m_cs = v;
        2: m_cr = v;
        3: m_cl = v;
        4: m_ow = v;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    chk_all(tag, e_trap, e_we, e_win, e_data);
    restore_i = 0; acct_i = 0; wr_en_i = 0;
  endtask

  task automatic wr(input int sel, input int val, input string tag);
    step(0, '0, '0, 0, 0, 1, sel, val, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_cwp = 0; m_cs = N-2; m_cr = 0; m_cl = N-1; m_ow = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, before any rising edge with reset released
    chk_all("R1", 0, 0, 0, '0);

    // R2 R3 R4 R5: restore from every window, including wrap at 0 and can-save saturation
    for (int p = 0; p < N; p++) begin
      wr(0, p, "R8");
      wr(2, 2, "R8");
      wr(1, p, "R8");
      step(1, DW'(p * 4099 + 77), DW'(16'hFFFF - p), 0, 0, 0, 0, 0, "R2 R4");
      step(1, DW'(16'h8000 + p), DW'(16'h8001), 0, 0, 0, 0, 0, "R3");
      step(1, DW'(5), DW'(6), 0, 0, 0, 0, 0, "R5");
    end

    // R6 R7: accounting over other-windows, can-restore, can-save, clean-windows corners
    for (int kd = 0; kd < 2; kd++)
      for (int ow = 0; ow < 2; ow++)
        for (int cr = 0; cr < 2; cr++)
          for (int cs = 0; cs < 2; cs++)
            for (int cl = 0; cl < 2; cl++) begin
              wr(4, ow, "R8");
              wr(2, cr * (N-1), "R8");
              wr(1, cs * (N-1), "R8");
              wr(3, N-2+cl, "R8");
              step(0, '0, '0, 1, logic'(kd), 0, 0, 0, (kd != 0) ? "R7" : "R6");
            end

    // R8: every select code with every value, including clamp and unused codes
    for (int s = 0; s < 8; s++)
      for (int v = 0; v < 8; v++)
        wr(s, v, "R8");

    // R9: precedence between simultaneous strobes
    wr(2, 2, "R9");
    wr(4, 1, "R9");
    step(1, DW'(100), DW'(23), 1, 1, 1, 4, 3, "R9");
    step(0, '0, '0, 1, 0, 1, 4, 3, "R9");
    wr(2, 0, "R9");
    step(1, DW'(1), DW'(2), 1, 1, 1, 1, 0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule